// File: doc/BRIEF.md
# Dual-Channel Interrupt Source Selector

This block drives two interrupt request lines. A small write-only control word picks, for each line on its own, what raises the request. The choices are nothing, a falling edge on one external port line, a two-line gating condition on a pair of port lines, or a one-cycle terminal-count pulse. Channel 1 takes its terminal count from an event counter, and channel 2 takes its terminal count from a timer.

The external port lines are asynchronous. They pass through a synchronizer before edge detection. Each detected event sets a sticky pending flag, and that flag is the request output. Software lowers the flag with a per-channel clear pulse. Changing a channel's mode code also drops its pending flag.

Top module: `irq_src_sel`

## Requirements
- R1: After reset the control word is 0000, and both `irq1_o` and `irq2_o` are low.
- R2: Control bits 1:0 set the channel 1 mode and bits 3:2 set the channel 2 mode. The codes are 00 off, 01 falling edge on C0, 10 two-line gating, and 11 terminal count. Channel 1 counts from `cnt_tc_i` and channel 2 counts from `tmr_tc_i`.
- R3: In mode 01, a high-to-low change on the channel's C0 line raises its request. The request goes high at the third rising clock edge after the change is first sampled.
- R4: In mode 10, no request is raised while C0 is high, and no request is raised while C3 is low.
- R5: In mode 10, a falling edge on C3 while C0 is low raises the request.
- R6: In mode 10, a rising edge on C0 while C3 is high raises the request.
- R7: In mode 11, a terminal-count pulse with no write in the same cycle raises the request at the next clock edge.
- R8: A channel in mode 00 never asserts its request. Writing one channel's field does not change the other channel's request.
- R9: A raised request stays high until the cycle after a clear pulse on that channel.
- R10: When an event and a clear pulse occur in the same cycle, the request is set.
- R11: A write that changes a channel's mode code lowers that channel's request at the next edge. A write that repeats the same code leaves the request as it is.
- R12: In mode 01, a rising edge on C0 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_data_i | input | 4 | Control word write data |
| p1_c0_i | input | 1 | Channel 1 port line C0 (asynchronous) |
| p1_c3_i | input | 1 | Channel 1 port line C3 (asynchronous) |
| p2_c0_i | input | 1 | Channel 2 port line C0 (asynchronous) |
| p2_c3_i | input | 1 | Channel 2 port line C3 (asynchronous) |
| cnt_tc_i | input | 1 | Event counter terminal-count pulse, one cycle |
| tmr_tc_i | input | 1 | Timer terminal-count pulse, one cycle |
| clr1_i | input | 1 | Channel 1 request clear pulse |
| clr2_i | input | 1 | Channel 2 request clear pulse |
| irq1_o | output | 1 | Channel 1 interrupt request |
| irq2_o | output | 1 | Channel 2 interrupt request |

## Verification
The properties assume that the terminal-count and clear inputs are single-cycle pulses, synchronous to the block clock. They also assume that a write always carries the full 4-bit word. The bench drives every input on the falling clock edge and pulses `cnt_tc_i`, `tmr_tc_i` and the clears for exactly one cycle. After a reset it waits several cycles before the first write, so that the synchronizer settling from its reset value into the idle-high port lines is never mistaken for an edge.

// File: rtl/irq_src_sel_pkg.sv
package irq_src_sel_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_FALL = 2'b01,
    SRC_GATE = 2'b10,
    SRC_TC   = 2'b11
  } src_mode_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_src_chan.sv
module irq_src_chan
  import irq_src_sel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  src_mode_e mode_i,
  input  logic      mode_chg_i,
  input  logic      c0_i,
  input  logic      c3_i,
  input  logic      tc_i,
  input  logic      clr_i,
  output logic      irq_o
);
  logic c0_q, c3_q, evt, pend_q;
  logic c0_rise, c0_fall, c3_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c0_q <= 1'b0;
      c3_q <= 1'b0;
    end else begin
      c0_q <= c0_i;
      c3_q <= c3_i;
    end
  end

  assign c0_rise = c0_i & ~c0_q;
  assign c0_fall = ~c0_i & c0_q;
  assign c3_fall = ~c3_i & c3_q;

  always_comb begin
    unique case (mode_i)
      SRC_FALL: evt = c0_fall;
      // C0 high or C3 low blocks every request
      SRC_GATE: evt = (c3_fall & ~c0_i) | (c0_rise & c3_i);
      SRC_TC:   evt = tc_i;
      default:  evt = 1'b0;
    endcase
  end

  // mode change beats event, event beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (mode_chg_i) pend_q <= 1'b0;
    else if (evt)        pend_q <= 1'b1;
    else if (clr_i)      pend_q <= 1'b0;
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/irq_src_sel.sv
module irq_src_sel
  import irq_src_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [3:0] cfg_data_i,
  input  logic       p1_c0_i,
  input  logic       p1_c3_i,
  input  logic       p2_c0_i,
  input  logic       p2_c3_i,
  input  logic       cnt_tc_i,
  input  logic       tmr_tc_i,
  input  logic       clr1_i,
  input  logic       clr2_i,
  output logic       irq1_o,
  output logic       irq2_o
);
  localparam int NCH   = 2;
  localparam int FLD_W = 2;
  localparam int CFG_W = NCH * FLD_W;

  logic [CFG_W-1:0] ctrl_q;
  logic [NCH-1:0]   c0_raw, c3_raw, c0_s, c3_s, tc, clr, irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (cfg_wr_i) ctrl_q <= cfg_data_i;
  end

  assign c0_raw = {p2_c0_i, p1_c0_i};
  assign c3_raw = {p2_c3_i, p1_c3_i};
  assign tc     = {tmr_tc_i, cnt_tc_i};
  assign clr    = {clr2_i, clr1_i};

  irq_line_sync #(.WIDTH(2*NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({c3_raw, c0_raw}),
    .q_o    ({c3_s, c0_s})
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [FLD_W-1:0] fld_cur, fld_new;
    assign fld_cur = ctrl_q[ch*FLD_W +: FLD_W];
    assign fld_new = cfg_data_i[ch*FLD_W +: FLD_W];

    irq_src_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (src_mode_e'(fld_cur)),
      .mode_chg_i (cfg_wr_i && (fld_new != fld_cur)),
      .c0_i       (c0_s[ch]),
      .c3_i       (c3_s[ch]),
      .tc_i       (tc[ch]),
      .clr_i      (clr[ch]),
      .irq_o      (irq[ch])
    );
  end

  assign irq1_o = irq[0];
  assign irq2_o = irq[1];
endmodule

// File: rtl/irq_src_sel_chk.sv
module irq_src_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_wr_i,
  input logic [3:0] cfg_data_i,
  input logic       cnt_tc_i,
  input logic       tmr_tc_i,
  input logic       clr1_i,
  input logic       clr2_i,
  input logic       irq1_o,
  input logic       irq2_o,
  input logic [1:0] mode1_i,
  input logic [1:0] mode2_i
);
  a_r8_off_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode1_i == 2'b00 |-> !irq1_o);
  a_r8_off_ch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode2_i == 2'b00 |-> !irq2_o);
  a_r7_tc_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_i == 2'b11 && cnt_tc_i && !cfg_wr_i) |=> irq1_o);
  a_r7_tc_ch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode2_i == 2'b11 && tmr_tc_i && !cfg_wr_i) |=> irq2_o);
  a_r10_evt_wins_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_i == 2'b11 && cnt_tc_i && clr1_i && !cfg_wr_i) |=> irq1_o);
  a_r9_sticky_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq1_o && !clr1_i && !cfg_wr_i) |=> irq1_o);
  a_r9_sticky_ch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq2_o && !clr2_i && !cfg_wr_i) |=> irq2_o);
  a_r11_chg_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_data_i[1:0] != mode1_i) |=> !irq1_o);
  a_r11_chg_ch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_data_i[3:2] != mode2_i) |=> !irq2_o);
endmodule

bind irq_src_sel irq_src_sel_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_data_i (cfg_data_i),
  .cnt_tc_i   (cnt_tc_i),
  .tmr_tc_i   (tmr_tc_i),
  .clr1_i     (clr1_i),
  .clr2_i     (clr2_i),
  .irq1_o     (irq1_o),
  .irq2_o     (irq2_o),
  .mode1_i    (ctrl_q[1:0]),
  .mode2_i    (ctrl_q[3:2])
);

// File: tb/irq_src_sel_tb.sv
module irq_src_sel_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 14;
  // {wr, data[3:0], cnt_tc, tmr_tc, clr1, clr2, exp_irq1, exp_irq2}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 4'b1111, 4'b0000, 2'b00}, // R2 both channels on terminal count
    {1'b0, 4'b0000, 4'b1000, 2'b10}, // R7 counter pulse -> ch1
    {1'b0, 4'b0000, 4'b0100, 2'b11}, // R7 timer pulse -> ch2
    {1'b0, 4'b0000, 4'b0010, 2'b01}, // R9 clear ch1
    {1'b0, 4'b0000, 4'b0000, 2'b01}, // R9 sticky ch2
    {1'b0, 4'b0000, 4'b1010, 2'b11}, // R10 event beats clear
    {1'b1, 4'b1111, 4'b0000, 2'b11}, // R11 same code keeps
    {1'b1, 4'b0011, 4'b0000, 2'b10}, // R11 ch2 off clears, R8 ch1 untouched
    {1'b0, 4'b0000, 4'b0100, 2'b10}, // R8 disabled ch2 ignores timer
    {1'b1, 4'b0100, 4'b0000, 2'b00}, // R11 ch1 off
    {1'b0, 4'b0000, 4'b1000, 2'b00}, // R8 disabled ch1 ignores counter
    {1'b1, 4'b1100, 4'b0000, 2'b00}, // R2 ch2 timer
    {1'b0, 4'b0000, 4'b0100, 2'b01}, // R7 timer only drives ch2
    {1'b0, 4'b0000, 4'b0001, 2'b00}  // R9 clear ch2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_data = '0;
  logic p1c0 = 1'b1, p1c3 = 1'b1, p2c0 = 1'b1, p2c3 = 1'b1;
  logic cnt_tc = 1'b0, tmr_tc = 1'b0, clr1 = 1'b0, clr2 = 1'b0;
  logic irq1, irq2;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data),
    .p1_c0_i(p1c0), .p1_c3_i(p1c3), .p2_c0_i(p2c0), .p2_c3_i(p2c3),
    .cnt_tc_i(cnt_tc), .tmr_tc_i(tmr_tc), .clr1_i(clr1), .clr2_i(clr2),
    .irq1_o(irq1), .irq2_o(irq2)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [3:0] d);
    cfg_wr = 1'b1; cfg_data = d;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_clr1();
    clr1 = 1'b1; cyc(1); clr1 = 1'b0;
  endtask

  initial begin
    cyc(2);
    chk("R1 irq1 in reset", irq1, 1'b0);
    chk("R1 irq2 in reset", irq2, 1'b0);
    rst_n = 1'b1;
    cyc(6);
    chk("R1 irq1 after reset", irq1, 1'b0);
    chk("R1 irq2 after reset", irq2, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      {cfg_wr, cfg_data, cnt_tc, tmr_tc, clr1, clr2} = VEC[i][10:2];
      cyc(1);
      chk($sformatf("vec %0d irq1", i), irq1, VEC[i][1]);
      chk($sformatf("vec %0d irq2", i), irq2, VEC[i][0]);
    end
    {cfg_wr, cfg_data, cnt_tc, tmr_tc, clr1, clr2} = '0;

    // R3 falling edge mode, latency
    wr_cfg(4'b0101);
    p1c0 = 1'b0;
    cyc(2);
    chk("R3 not yet", irq1, 1'b0);
    cyc(1);
    chk("R3 falling C0 ch1", irq1, 1'b1);
    chk("R8 ch2 unaffected", irq2, 1'b0);
    pulse_clr1();
    p1c0 = 1'b1;
    cyc(5);
    chk("R12 rising C0 ignored", irq1, 1'b0);
    p2c0 = 1'b0;
    cyc(5);
    chk("R3 falling C0 ch2", irq2, 1'b1);
    clr2 = 1'b1; cyc(1); clr2 = 1'b0;
    p2c0 = 1'b1;
    cyc(5);
    chk("R9 ch2 cleared", irq2, 1'b0);

    // two-line gating, ch1 (C0=1, C3=1 here)
    wr_cfg(4'b1010);
    p1c3 = 1'b0; cyc(5);
    chk("R4 C0 high blocks C3 fall", irq1, 1'b0);
    p1c0 = 1'b0; cyc(5);
    chk("R4 C0 fall no request", irq1, 1'b0);
    p1c0 = 1'b1; cyc(5);
    chk("R4 C3 low blocks C0 rise", irq1, 1'b0);
    p1c0 = 1'b0; p1c3 = 1'b1; cyc(5);
    chk("R4 C3 rise no request", irq1, 1'b0);
    p1c3 = 1'b0; cyc(5);
    chk("R5 C3 fall with C0 low", irq1, 1'b1);
    pulse_clr1();
    p1c3 = 1'b1; cyc(5);
    chk("R5 cleared, C3 rise quiet", irq1, 1'b0);
    p1c0 = 1'b1; cyc(5);
    chk("R6 C0 rise with C3 high", irq1, 1'b1);
    chk("R8 ch2 quiet", irq2, 1'b0);
    wr_cfg(4'b1000);
    chk("R11 mode change clears ch1", irq1, 1'b0);

    // R6 on ch2 (C0=1, C3=1)
    p2c0 = 1'b0; cyc(5);
    chk("R6 ch2 C0 fall quiet", irq2, 1'b0);
    p2c0 = 1'b1; cyc(5);
    chk("R6 ch2 C0 rise with C3 high", irq2, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule